// File: doc/BRIEF.md
# Four-Lane Skip-Column Elastic Buffer

This block sits in a four-lane 8b/10b receive path, after the lanes have been aligned to words and deskewed against each other. Columns arrive on the recovered write clock. Each column holds one byte and one control-detect bit per lane. The block hands the columns to the local read clock through a 20-column elastic store. The two clocks may differ by a small frequency offset. The block absorbs that offset by acting on idle columns in which every lane carries the /R/ control character. It drops such a column when the store is running full and repeats one when the store is running dry.

The store stays frozen until both the word-lock and the lane-lock inputs are high. Once writing begins, the read side waits until half the store is filled before it starts to read. A column in which only some lanes carry /R/ counts as ordinary data. A stream without complete /R/ columns therefore cannot be compensated. If the store then overflows or runs dry, the read side switches to a fixed fault column and holds it until the block is reset. Pointers cross between the clock domains as Gray codes through two-flop synchronizers.

Top module: `rate_match_x4`

## Requirements
- R1: While reset is held, and after it is released until reading starts, the output column is idle. Idle means every lane carries byte 8'h1C with its control bit set (rd_data = 32'h1C1C1C1C, rd_ctl = 4'hF). Lane i occupies rd_data[8i+7:8i] and rd_ctl[i]. Both pulse outputs and both error flags are low.
- R2: While either wr_word_locked or wr_lanes_locked is low, no column is stored, neither pointer moves, and the output stays idle.
- R3: After both lock inputs go high, reading begins once at least 10 columns are buffered. From then on, every column that is not a complete /R/ column leaves the block in the order it arrived, with nothing lost or duplicated.
- R4: When the write side sees 16 or more buffered columns and a complete /R/ column arrives, that column is discarded. wr_del_pulse goes high for one write cycle, with the discarded column still on the inputs.
- R5: When the read side sees 4 or fewer buffered columns and the column at the head is a complete /R/ column, that column is output twice. rd_ins_pulse goes high for one read cycle together with the repeated copy.
- R6: A single /R/ column is removed at most once or repeated at most once. Neither pulse output is high in two consecutive cycles of its clock.
- R7: A column in which only some lanes carry /R/ is never discarded or repeated.
- R8: A write into a full store of 20 columns sets wr_overflow, which stays high until reset. The read side then outputs the fault column: lane 0 carries 8'h9C with its control bit set, and lanes 1 to 3 carry 8'h00 with their control bits clear (rd_data = 32'h0000009C, rd_ctl = 4'h1).
- R9: A read from an empty store sets rd_underflow, which stays high until reset, and the output holds the same fault column.
- R10: Reset clears both error flags and returns the output to the idle column.
- R11: Compensation keeps the data intact for write clocks up to 2000 PPM faster or slower than the read clock, provided complete /R/ columns appear regularly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| rd_clk | input | 1 | Local read clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously in each domain |
| wr_word_locked | input | 1 | Word alignment achieved (write domain) |
| wr_lanes_locked | input | 1 | Lane alignment achieved (write domain) |
| wr_data | input | 32 | Incoming column bytes, lane i at bits 8i+7:8i |
| wr_ctl | input | 4 | Incoming control-detect bits, one per lane |
| rd_data | output | 32 | Compensated column bytes (read domain) |
| rd_ctl | output | 4 | Compensated control-detect bits |
| rd_ins_pulse | output | 1 | One-cycle pulse marking a repeated /R/ column |
| rd_underflow | output | 1 | Sticky underflow flag (read domain) |
| wr_del_pulse | output | 1 | One-cycle pulse marking a discarded /R/ column (write domain) |
| wr_overflow | output | 1 | Sticky overflow flag (write domain) |

## Verification
The bench runs the write clock 2000 PPM fast and then 2000 PPM slow. It mixes random data columns with complete and partial /R/ columns and compares the non-idle output sequence against a queue. A design that dropped or repeated a partial /R/ column, or that acted twice on one column, would show up as a miscompare or as back-to-back pulses. The bench holds the locks apart to catch a store that fills before both locks are high, and it measures the delay before the first data column appears. Runs at 2.5 % offset with no complete /R/ columns must end in the sticky fault column, which a design that kept compensating or cleared the fault without reset would fail to show.

// File: rtl/rm_pkg.sv
package rm_pkg;

  localparam logic [7:0] SKIP_CODE  = 8'h1C;
  localparam logic [7:0] FAULT_CODE = 8'h9C;

  function automatic logic lane_is_skip(input logic [7:0] byte_v, input logic k_v);
    return k_v && (byte_v == SKIP_CODE);
  endfunction

endpackage

// File: rtl/rm_sync.sv
module rm_sync #(
  parameter int           W  = 1,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RV;
      q    <= RV;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/rm_mem.sv
module rm_mem #(
  parameter int W     = 36,
  parameter int DEPTH = 20,
  parameter int AW    = 5
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/rm_wr_ctrl.sv
module rm_wr_ctrl import rm_pkg::*; #(
  parameter int LANES   = 4,
  parameter int DEPTH   = 20,
  parameter int HI_MARK = 16,
  parameter int PW      = 6,
  parameter int AW      = 5,
  parameter int CW      = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_ok,
  input  logic               chan_ok,
  input  logic [LANES*8-1:0] col_data,
  input  logic [LANES-1:0]   col_ctl,
  input  logic [PW-1:0]      rgray_s,
  output logic               mem_we,
  output logic [AW-1:0]      mem_waddr,
  output logic [CW-1:0]      mem_wdata,
  output logic [PW-1:0]      wgray,
  output logic               active_q,
  output logic               del_q,
  output logic               ovf_q
);

  localparam int TWO_D = 2 * DEPTH;
  localparam int GOFS  = ((1 << PW) - TWO_D) / 2;
  localparam logic [PW-1:0] GOFS_V = PW'(GOFS);
  localparam logic [PW-1:0] GRST   = GOFS_V ^ (GOFS_V >> 1);

  logic              aligned;
  logic [LANES-1:0]  lane_r;
  logic              col_skip;
  logic [PW-1:0]     rbin_g, rptr_w;
  logic [PW:0]       diff, fill;
  logic [PW-1:0]     wptr, wptr_n, gsum;
  logic [PW-1:0]     wgray_n;
  logic              del_n, ovf_n, ptr_en;

  assign aligned = word_ok & chan_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_r[i] = lane_is_skip(col_data[8*i +: 8], col_ctl[i]);
  end
  assign col_skip = &lane_r;

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign rbin_g[i] = ^rgray_s[PW-1:i];
  end
  assign rptr_w = rbin_g - GOFS_V;

  always_comb begin
    diff = {1'b0, wptr} + (PW+1)'(TWO_D) - {1'b0, rptr_w};
    fill = (diff >= (PW+1)'(TWO_D)) ? diff - (PW+1)'(TWO_D) : diff;
  end

  always_comb begin
    wptr_n = wptr;
    del_n  = 1'b0;
    ovf_n  = ovf_q;
    ptr_en = 1'b0;
    if (aligned && !ovf_q) begin
      if (col_skip && (fill >= (PW+1)'(HI_MARK)) && !del_q) begin
        del_n = 1'b1;
      end else if (fill >= (PW+1)'(DEPTH)) begin
        ovf_n = 1'b1;
      end else begin
        ptr_en = 1'b1;
        wptr_n = (wptr == PW'(TWO_D - 1)) ? '0 : wptr + 1'b1;
      end
    end
  end

  assign gsum    = wptr_n + GOFS_V;
  assign wgray_n = gsum ^ (gsum >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      wgray    <= GRST;
      del_q    <= 1'b0;
      ovf_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (ptr_en) begin
        wptr  <= wptr_n;
        wgray <= wgray_n;
      end
      del_q    <= del_n;
      ovf_q    <= ovf_n;
      active_q <= aligned;
    end
  end

  assign mem_we    = ptr_en;
  assign mem_waddr = AW'((wptr >= PW'(DEPTH)) ? wptr - PW'(DEPTH) : wptr);
  assign mem_wdata = {col_ctl, col_data};

  assert_freeze_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_ok && chan_ok) |=> $stable(wptr));

  assert_single_del_R6: assert property (@(posedge clk) disable iff (!rst_n)
    del_q |=> !del_q);

  assert_fill_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (PW+1)'(DEPTH));

  assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/rm_rd_ctrl.sv
module rm_rd_ctrl import rm_pkg::*; #(
  parameter int LANES      = 4,
  parameter int DEPTH      = 20,
  parameter int LO_MARK    = 4,
  parameter int START_FILL = 10,
  parameter int PW         = 6,
  parameter int AW         = 5,
  parameter int CW         = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_s,
  input  logic          ovf_s,
  input  logic [PW-1:0] wgray_s,
  input  logic [CW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [PW-1:0] rgray,
  output logic [CW-1:0] out_q,
  output logic          ins_q,
  output logic          unf_q
);

  localparam int TWO_D = 2 * DEPTH;
  localparam int GOFS  = ((1 << PW) - TWO_D) / 2;
  localparam logic [PW-1:0] GOFS_V = PW'(GOFS);
  localparam logic [PW-1:0] GRST   = GOFS_V ^ (GOFS_V >> 1);
  localparam logic [CW-1:0] IDLE_COL  = {{LANES{1'b1}}, {LANES{SKIP_CODE}}};
  localparam logic [CW-1:0] FAULT_COL = {{(LANES-1){1'b0}}, 1'b1,
                                          {((LANES-1)*8){1'b0}}, FAULT_CODE};

  logic [LANES-1:0] head_r, outr;
  logic             head_skip, out_skip;
  logic [PW-1:0]    wbin_g, wptr_r;
  logic [PW:0]      diff, fill;
  logic [PW-1:0]    rptr, rptr_n, gsum, rgray_n;
  logic             start_q, start_n, rep_q, rep_n, ins_n, unf_n, ptr_en;
  logic [CW-1:0]    out_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign head_r[i] = lane_is_skip(mem_rdata[8*i +: 8], mem_rdata[LANES*8 + i]);
    assign outr[i]   = lane_is_skip(out_q[8*i +: 8], out_q[LANES*8 + i]);
  end
  assign head_skip = &head_r;
  assign out_skip  = &outr;

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign wbin_g[i] = ^wgray_s[PW-1:i];
  end
  assign wptr_r = wbin_g - GOFS_V;

  always_comb begin
    diff = {1'b0, wptr_r} + (PW+1)'(TWO_D) - {1'b0, rptr};
    fill = (diff >= (PW+1)'(TWO_D)) ? diff - (PW+1)'(TWO_D) : diff;
  end

  always_comb begin
    rptr_n  = rptr;
    ptr_en  = 1'b0;
    start_n = start_q;
    rep_n   = rep_q;
    ins_n   = 1'b0;
    unf_n   = unf_q;
    out_n   = IDLE_COL;
    if (unf_q || ovf_s) begin
      out_n = FAULT_COL;
    end else if (!start_q) begin
      if (active_s && (fill >= (PW+1)'(START_FILL))) start_n = 1'b1;
    end else if (fill == '0) begin
      unf_n = 1'b1;
      out_n = FAULT_COL;
    end else begin
      out_n = mem_rdata;
      if (head_skip && (fill <= (PW+1)'(LO_MARK)) && !rep_q) begin
        rep_n = 1'b1;
        ins_n = 1'b1;
      end else begin
        rep_n  = 1'b0;
        ptr_en = 1'b1;
        rptr_n = (rptr == PW'(TWO_D - 1)) ? '0 : rptr + 1'b1;
      end
    end
  end

  assign gsum    = rptr_n + GOFS_V;
  assign rgray_n = gsum ^ (gsum >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      rgray   <= GRST;
      start_q <= 1'b0;
      rep_q   <= 1'b0;
      ins_q   <= 1'b0;
      unf_q   <= 1'b0;
      out_q   <= IDLE_COL;
    end else begin
      if (ptr_en) begin
        rptr  <= rptr_n;
        rgray <= rgray_n;
      end
      start_q <= start_n;
      rep_q   <= rep_n;
      ins_q   <= ins_n;
      unf_q   <= unf_n;
      out_q   <= out_n;
    end
  end

  assign mem_raddr = AW'((rptr >= PW'(DEPTH)) ? rptr - PW'(DEPTH) : rptr);

  assert_freeze_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |=> $stable(rptr));

  assert_single_ins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_q |=> !ins_q);

  assert_ins_is_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_q |-> out_skip);

  assert_fault_unf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> (out_q == FAULT_COL));

  assert_unf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q);

  assert_fault_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_s |=> (out_q == FAULT_COL));

endmodule

// File: rtl/rate_match_x4.sv
module rate_match_x4 #(
  parameter int LANES      = 4,
  parameter int DEPTH      = 20,
  parameter int HI_MARK    = 16,
  parameter int LO_MARK    = 4,
  parameter int START_FILL = 10
) (
  input  logic               wr_clk,
  input  logic               rd_clk,
  input  logic               rst_n,
  input  logic               wr_word_locked,
  input  logic               wr_lanes_locked,
  input  logic [LANES*8-1:0] wr_data,
  input  logic [LANES-1:0]   wr_ctl,
  output logic [LANES*8-1:0] rd_data,
  output logic [LANES-1:0]   rd_ctl,
  output logic               rd_ins_pulse,
  output logic               rd_underflow,
  output logic               wr_del_pulse,
  output logic               wr_overflow
);

  localparam int PW   = $clog2(2 * DEPTH);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = LANES * 9;
  localparam int GOFS = ((1 << PW) - 2 * DEPTH) / 2;
  localparam logic [PW-1:0] GOFS_V = PW'(GOFS);
  localparam logic [PW-1:0] GRST   = GOFS_V ^ (GOFS_V >> 1);

  logic          wr_rst_n, rd_rst_n;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [CW-1:0] mem_wdata, mem_rdata, out_col;
  logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
  logic          active_w, active_s, ovf_s;

  rm_sync #(.W(1), .RV(1'b0)) u_wr_rst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n));

  rm_sync #(.W(1), .RV(1'b0)) u_rd_rst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n));

  rm_wr_ctrl #(
    .LANES(LANES), .DEPTH(DEPTH), .HI_MARK(HI_MARK),
    .PW(PW), .AW(AW), .CW(CW)
  ) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n),
    .word_ok(wr_word_locked), .chan_ok(wr_lanes_locked),
    .col_data(wr_data), .col_ctl(wr_ctl),
    .rgray_s(rgray_s),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wgray(wgray), .active_q(active_w),
    .del_q(wr_del_pulse), .ovf_q(wr_overflow)
  );

  rm_mem #(.W(CW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  rm_sync #(.W(PW), .RV(GRST)) u_wptr_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));

  rm_sync #(.W(PW), .RV(GRST)) u_rptr_sync (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));

  rm_sync #(.W(2), .RV(2'b00)) u_flag_sync (
    .clk(rd_clk), .rst_n(rd_rst_n),
    .d({wr_overflow, active_w}), .q({ovf_s, active_s}));

  rm_rd_ctrl #(
    .LANES(LANES), .DEPTH(DEPTH), .LO_MARK(LO_MARK), .START_FILL(START_FILL),
    .PW(PW), .AW(AW), .CW(CW)
  ) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n),
    .active_s(active_s), .ovf_s(ovf_s),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .rgray(rgray), .out_q(out_col),
    .ins_q(rd_ins_pulse), .unf_q(rd_underflow)
  );

  assign rd_data = out_col[LANES*8-1:0];
  assign rd_ctl  = out_col[CW-1:LANES*8];

endmodule

// File: tb/rate_match_x4_test.sv
module rate_match_x4_test;

  localparam int RD_HALF = 2000;   // 250 MHz read clock, 1 ps time unit
  localparam logic [35:0] IDLE  = {4'hF, 32'h1C1C1C1C};
  localparam logic [35:0] FAULT = {4'h1, 32'h0000009C};

  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic        wr_word_locked = 1'b0, wr_lanes_locked = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic [3:0]  wr_ctl = 4'h0;
  logic [31:0] rd_data;
  logic [3:0]  rd_ctl;
  logic        rd_ins_pulse, rd_underflow, wr_del_pulse, wr_overflow;

  int wr_half = 2000;
  int n_chk = 0, n_bad = 0, n_del = 0, n_ins = 0;
  bit word_drv = 0, lane_drv = 0, full_ok = 1, mon_en = 0, done = 0;
  logic [35:0] exp_q[$];

  rate_match_x4 uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_word_locked(wr_word_locked), .wr_lanes_locked(wr_lanes_locked),
    .wr_data(wr_data), .wr_ctl(wr_ctl),
    .rd_data(rd_data), .rd_ctl(rd_ctl),
    .rd_ins_pulse(rd_ins_pulse), .rd_underflow(rd_underflow),
    .wr_del_pulse(wr_del_pulse), .wr_overflow(wr_overflow)
  );

  always #(RD_HALF) rd_clk = ~rd_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  function automatic bit full_skip(input logic [35:0] c);
    return c == IDLE;
  endfunction

  function automatic logic [35:0] gen_col(input bit allow_full);
    logic [35:0] c;
    int r;
    r = $urandom_range(0, 7);
    c = {4'h0, $urandom()};
    if (r == 0 && allow_full) begin
      c = IDLE;
    end else if (r <= 1) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 14));
      for (int i = 0; i < 4; i++)
        if (m[i]) begin c[8*i +: 8] = 8'h1C; c[32+i] = 1'b1; end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  // write-side driver and deletion monitor
  initial begin
    logic [35:0] c;
    bit prev_del = 0;
    void'($urandom(32'h5EED1234));
    forever begin
      @(negedge wr_clk);
      if (wr_del_pulse) begin
        n_del++;
        check(!prev_del, "R6", "back-to-back delete", 36'(prev_del), 36'h0);
        check(full_skip({wr_ctl, wr_data}), "R4", "deleted column not /R/",
              {wr_ctl, wr_data}, IDLE);
      end
      prev_del = wr_del_pulse;
      c = gen_col(full_ok);
      {wr_ctl, wr_data} = c;
      wr_word_locked  = word_drv;
      wr_lanes_locked = lane_drv;
      if (rst_n && word_drv && lane_drv && !full_skip(c)) exp_q.push_back(c);
    end
  end

  // read-side scoreboard and insertion monitor
  initial begin
    logic [35:0] o, e;
    bit prev_ins = 0;
    forever begin
      @(negedge rd_clk);
      o = {rd_ctl, rd_data};
      if (rd_ins_pulse) begin
        n_ins++;
        check(!prev_ins, "R6", "back-to-back insert", 36'(prev_ins), 36'h0);
        check(full_skip(o), "R5", "repeated column not /R/", o, IDLE);
      end
      prev_ins = rd_ins_pulse;
      if (mon_en && !full_skip(o)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected column", o, 36'h0);
        end else begin
          e = exp_q.pop_front();
          check(o == e, "R3", "column order", o, e);
        end
      end
    end
  end

  task automatic do_reset();
    mon_en = 0; word_drv = 0; lane_drv = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge rd_clk);
    exp_q.delete();
    rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic check_idle(input string req);
    check({rd_ctl, rd_data} == IDLE, req, "idle column", {rd_ctl, rd_data}, IDLE);
    check({rd_ins_pulse, rd_underflow, wr_del_pulse, wr_overflow} == 4'h0, req,
          "pulses and flags low",
          36'({rd_ins_pulse, rd_underflow, wr_del_pulse, wr_overflow}), 36'h0);
  endtask

  task automatic run_fault(input int half, input bit use_ovf, input string req);
    int del0, ins0, waited;
    do_reset();
    wr_half = half; full_ok = 0;
    del0 = n_del; ins0 = n_ins;
    word_drv = 1; lane_drv = 1;
    waited = 0;
    while (!(use_ovf ? wr_overflow : rd_underflow) && waited < 6000) begin
      @(negedge rd_clk);
      waited++;
    end
    check(use_ovf ? wr_overflow : rd_underflow, req, "error flag set", 36'(waited), 36'h0);
    repeat (10) @(negedge rd_clk);
    for (int k = 0; k < 100; k++) begin
      @(negedge rd_clk);
      check({rd_ctl, rd_data} == FAULT, req, "fault column held", {rd_ctl, rd_data}, FAULT);
    end
    check(use_ovf ? wr_overflow : rd_underflow, req, "flag sticky", 36'h0, 36'h1);
    check(n_del == del0 && n_ins == ins0, "R7", "partial /R/ columns compensated",
          36'(n_del - del0 + n_ins - ins0), 36'h0);
    do_reset();
    check_idle("R10");
    full_ok = 1;
  endtask

  initial begin
    int lat, d0, i0;
    rst_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    check_idle("R1");

    // R2: only one lock at a time, nothing may come out
    word_drv = 1;
    for (int k = 0; k < 800; k++) begin
      @(negedge rd_clk);
      if (k % 100 == 0) check_idle("R2");
    end
    word_drv = 0; lane_drv = 1;
    for (int k = 0; k < 800; k++) begin
      @(negedge rd_clk);
      if (k % 100 == 0) check_idle("R2");
    end
    check({rd_ctl, rd_data} == IDLE, "R2", "idle after partial lock", {rd_ctl, rd_data}, IDLE);

    // R3: start latency at half fill, then equal-rate integrity
    mon_en = 1; word_drv = 1;
    lat = 0;
    while (full_skip({rd_ctl, rd_data}) && lat < 200) begin
      @(negedge rd_clk);
      lat++;
    end
    check(lat >= 10 && lat < 40, "R3", "start latency", 36'(lat), 36'd10);
    repeat (3000) @(negedge rd_clk);

    // R4 / R11: write clock 2000 PPM fast
    do_reset();
    wr_half = 1996; d0 = n_del;
    word_drv = 1; lane_drv = 1; mon_en = 1;
    repeat (8000) @(negedge rd_clk);
    check(n_del > d0, "R4", "deletions seen", 36'(n_del - d0), 36'h1);
    check(!wr_overflow && !rd_underflow, "R11", "no error fast", 36'({wr_overflow, rd_underflow}), 36'h0);

    // R5 / R11: write clock 2000 PPM slow
    do_reset();
    wr_half = 2004; i0 = n_ins;
    word_drv = 1; lane_drv = 1; mon_en = 1;
    repeat (8000) @(negedge rd_clk);
    check(n_ins > i0, "R5", "insertions seen", 36'(n_ins - i0), 36'h1);
    check(!wr_overflow && !rd_underflow, "R11", "no error slow", 36'({wr_overflow, rd_underflow}), 36'h0);

    // R8 / R9 / R7 / R10: no complete /R/ columns, large offset
    run_fault(1950, 1'b1, "R8");
    run_fault(2050, 1'b0, "R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(64'd700000000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule